// File: doc/BRIEF.md
# Translation Table Region Selector

This block is the first step of a two-region address translation front end. Each request carries a 64-bit input address. The block also receives the configuration of two translation-table regions: a size field, a tag-ignore enable, a disable bit and a granule size (log2) for each region. It decides which region's table governs the address, or reports a translation fault. For the chosen region it also works out the walk parameters that the table walker needs: the input address width, the per-level stride and the level at which the walk starts.

The decision logic is purely combinational. It is captured in one register stage, so every result appears one clock after the request, together with a valid flag. A region whose granule or size yields no usable starting level produces a configuration fault instead of walk parameters. The block does not read descriptors, check permissions or cache translations.

Top module: `ttr_region_sel`

## Requirements
- R1: Results are registered. `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. Reset clears `out_valid` and every result field.
- R2: Address bit 55 picks which tag-ignore enable is in force. When the bit is 1, the region-1 enable applies. When it is 0, the region-0 enable applies. This holds for both membership tests.
- R3: While tag-ignore is in force, address bits 63..56 take no part in either membership test.
- R4: Region 0 (`out_region`=0) is chosen when its size field S0 is nonzero and all checked bits are zero. The checked bits are positions 64-S0 through 63, less the ignored tag bits. An empty checked set counts as all zero. Region 0 takes priority over region 1.
- R5: Region 1 (`out_region`=1) is chosen when its size field S1 is nonzero, region 0 was not chosen, and all of its checked bits are one. An empty set counts as all one.
- R6: If S0 is zero, region 0 takes every address that region 1 does not claim. Otherwise, if S1 is zero, region 1 takes every address that region 0 does not claim. When both size fields are zero, region 0 is chosen.
- R7: With both size fields nonzero, an address in neither region sets `out_fault`.
- R8: If the chosen region's disable bit is set, `out_fault` is set.
- R9: With no fault, `out_in_size` = 64 - S and `out_stride` = G - 3. Here S and G are the chosen region's size field and granule log2.
- R10: With no fault, `out_level` = 4 - floor((`out_in_size` - 4) / `out_stride`). If the input size is below 4, or the result falls outside 0..3, `out_cfg_fault` is set instead.
- R11: A chosen-region granule log2 other than 12, 14 or 16 sets `out_cfg_fault`. `out_fault` and `out_cfg_fault` are never both set. On either fault, `out_in_size`, `out_stride` and `out_level` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_addr | input | 64 | Input address |
| r0_size | input | 6 | Region 0 size field |
| r1_size | input | 6 | Region 1 size field |
| r0_tag_ign | input | 1 | Region 0 tag-ignore enable |
| r1_tag_ign | input | 1 | Region 1 tag-ignore enable |
| r0_off | input | 1 | Region 0 disabled |
| r1_off | input | 1 | Region 1 disabled |
| r0_gran | input | 5 | Region 0 granule log2 |
| r1_gran | input | 5 | Region 1 granule log2 |
| out_valid | output | 1 | Result present |
| out_fault | output | 1 | Translation fault |
| out_cfg_fault | output | 1 | Configuration fault |
| out_region | output | 1 | Chosen region |
| out_in_size | output | 7 | Input address width |
| out_stride | output | 5 | Bits resolved per level |
| out_level | output | 2 | Starting lookup level |

## Verification
The sweep covers the following corners, each with the symptom a faulty design would show:
- **Tag-enable selection.** The bench sets the two tag-ignore enables differently and flips bit 55. A design that read the wrong enable would claim or fault addresses whose tag byte is nonzero.
- **Small size fields.** These are checked with tag-ignore on, so the checked set is empty. A design that did not treat the empty set as matching would fault where a region should be chosen.
- **Zero size fields.** These exercise the fallback rules. Wrong fallback priority would swap region 0 and region 1.
- **Large size fields and odd granules.** These push the starting-level formula outside 0..3. A design with a bad divide or bad range handling would report walk parameters instead of a configuration fault.

// File: rtl/ttr_region_sel.sv
module ttr_region_sel #(
  parameter int AW      = 64,
  parameter int SW      = 6,
  parameter int GW      = 5,
  parameter int TAG_BIT = 55,
  parameter int TAG_W   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [SW-1:0] r0_size,
  input  logic [SW-1:0] r1_size,
  input  logic          r0_tag_ign,
  input  logic          r1_tag_ign,
  input  logic          r0_off,
  input  logic          r1_off,
  input  logic [GW-1:0] r0_gran,
  input  logic [GW-1:0] r1_gran,
  output logic          out_valid,
  output logic          out_fault,
  output logic          out_cfg_fault,
  output logic          out_region,
  output logic [6:0]    out_in_size,
  output logic [GW-1:0] out_stride,
  output logic [1:0]    out_level
);
  localparam int IW = 7;

  function automatic logic [AW-1:0] upper_mask(input logic [SW-1:0] sz);
    logic [AW-1:0] m;
    m = '1;
    if (sz == '0) upper_mask = '0;
    else          upper_mask = m << (AW - int'(sz));
  endfunction

  logic          tag_on;
  logic [AW-1:0] keep, chk0, chk1;
  logic          in0, in1, sel_ok, sel_r, tfault, gran_ok, level_ok, cfault;
  logic [SW-1:0] sz;
  logic [GW-1:0] gran, stride;
  logic [IW-1:0] in_size, quot;

  assign tag_on = in_addr[TAG_BIT] ? r1_tag_ign : r0_tag_ign;
  assign keep   = tag_on ? {{TAG_W{1'b0}}, {(AW-TAG_W){1'b1}}} : '1;
  assign chk0   = upper_mask(r0_size) & keep;
  assign chk1   = upper_mask(r1_size) & keep;
  assign in0    = (r0_size != '0) && ((in_addr & chk0) == '0);
  assign in1    = (r1_size != '0) && ((in_addr & chk1) == chk1);

  always_comb begin
    sel_ok = 1'b1;
    sel_r  = 1'b0;
    if (in0)                  sel_r = 1'b0;
    else if (in1)             sel_r = 1'b1;
    else if (r0_size == '0)   sel_r = 1'b0;
    else if (r1_size == '0)   sel_r = 1'b1;
    else                      sel_ok = 1'b0;
  end

  assign tfault  = !sel_ok || (sel_r ? r1_off : r0_off);
  assign sz      = sel_r ? r1_size : r0_size;
  assign gran    = sel_r ? r1_gran : r0_gran;
  assign gran_ok = (gran == GW'(12)) || (gran == GW'(14)) || (gran == GW'(16));
  assign stride  = gran - GW'(3);
  assign in_size = IW'(AW) - IW'(sz);

  always_comb begin
    quot = '0;
    if (gran_ok && in_size >= IW'(4))
      quot = (in_size - IW'(4)) / IW'(stride);
  end

  assign level_ok = (in_size >= IW'(4)) && (quot >= IW'(1)) && (quot <= IW'(4));
  assign cfault   = !tfault && !(gran_ok && level_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_fault     <= 1'b0;
      out_cfg_fault <= 1'b0;
      out_region    <= 1'b0;
      out_in_size   <= '0;
      out_stride    <= '0;
      out_level     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault     <= tfault;
        out_cfg_fault <= cfault;
        out_region    <= sel_r;
        if (tfault || cfault) begin
          out_in_size <= '0;
          out_stride  <= '0;
          out_level   <= '0;
        end else begin
          out_in_size <= in_size;
          out_stride  <= stride;
          out_level   <= 2'(IW'(4) - quot);
        end
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_BOTH_ZERO_R0: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && r0_size == '0 && r1_size == '0 && !r0_off |=> !out_fault && !out_region); // R6
  AST_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n) in_valid && r0_off && r1_off |=> out_fault); // R8
  AST_STRIDE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fault && !out_cfg_fault |-> out_stride inside {GW'(9), GW'(11), GW'(13)}); // R9
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_fault && out_cfg_fault)); // R11
endmodule

// File: tb/ttr_region_sel_tb.sv
`timescale 1ns/1ps
module ttr_region_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [5:0]  r0_size = '0, r1_size = '0;
  logic        r0_tag_ign = 1'b0, r1_tag_ign = 1'b0, r0_off = 1'b0, r1_off = 1'b0;
  logic [4:0]  r0_gran = 5'd12, r1_gran = 5'd12;
  logic        out_valid, out_fault, out_cfg_fault, out_region;
  logic [6:0]  out_in_size;
  logic [4:0]  out_stride;
  logic [1:0]  out_level;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ttr_region_sel dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .r0_size(r0_size), .r1_size(r1_size), .r0_tag_ign(r0_tag_ign), .r1_tag_ign(r1_tag_ign),
    .r0_off(r0_off), .r1_off(r1_off), .r0_gran(r0_gran), .r1_gran(r1_gran),
    .out_valid(out_valid), .out_fault(out_fault), .out_cfg_fault(out_cfg_fault),
    .out_region(out_region), .out_in_size(out_in_size), .out_stride(out_stride),
    .out_level(out_level));

  task automatic compare(input string tag, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h s0=%0d s1=%0d got=%h exp=%h", tag, in_addr, r0_size, r1_size, got, exp);
    end
  endtask

  function automatic logic [16:0] model(output string tag);
    bit tag_on, z0, o1, in0, in1, ok, r, tf, cf;
    int s, g, isz, q, lvl;
    tag_on = in_addr[55] ? r1_tag_ign : r0_tag_ign;
    z0 = 1'b1; o1 = 1'b1;
    for (int p = 0; p < 64; p++) begin
      if (p >= 64 - int'(r0_size) && !(tag_on && p >= 56) && in_addr[p]) z0 = 1'b0;
      if (p >= 64 - int'(r1_size) && !(tag_on && p >= 56) && !in_addr[p]) o1 = 1'b0;
    end
    in0 = (r0_size != 0) && z0;
    in1 = (r1_size != 0) && o1;
    ok = 1'b1; r = 1'b0;
    if (in0) r = 1'b0;
    else if (in1) r = 1'b1;
    else if (r0_size == 0) r = 1'b0;
    else if (r1_size == 0) r = 1'b1;
    else ok = 1'b0;
    tf = !ok || (r ? r1_off : r0_off);
    s = r ? int'(r1_size) : int'(r0_size);
    g = r ? int'(r1_gran) : int'(r0_gran);
    isz = 64 - s;
    lvl = -1;
    if ((g == 12 || g == 14 || g == 16) && isz >= 4) begin
      q = (isz - 4) / (g - 3);
      lvl = 4 - q;
    end
    cf = !tf && !(lvl >= 0 && lvl <= 3);
    if (!ok) tag = "R7";
    else if (tf) tag = "R8";
    else if (cf) tag = (g == 12 || g == 14 || g == 16) ? "R10" : "R11";
    else if (tag_on) tag = "R3";
    else if ((r ? r1_size : r0_size) == 0) tag = "R6";
    else tag = r ? "R5" : "R4";
    if (tf || cf) model = {tf, cf, r, 7'd0, 5'd0, 2'd0};
    else model = {1'b0, 1'b0, r, 7'(isz), 5'(g - 3), 2'(lvl)};
  endfunction

  task automatic run_vec(input string force_tag);
    logic [16:0] e;
    string t;
    e = model(t);
    if (force_tag != "") t = force_tag;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(t, {out_fault, out_cfg_fault, out_region, out_in_size, out_stride, out_level}, e);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int          tl[9] = '{0, 1, 8, 9, 16, 25, 33, 40, 63};
    int          g0l[3] = '{12, 14, 16};
    int          g1l[3] = '{16, 13, 12};
    logic [63:0] al[11] = '{64'h0, '1, 64'hFF00_0000_0000_0000, 64'h00FF_FFFF_FFFF_FFFF,
                            64'h0080_0000_0000_0000, 64'hFF7F_FFFF_FFFF_FFFF, 64'h0000_0000_1234_5678,
                            64'hFFFF_FFFF_8000_0000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                            64'hAB80_0000_0000_0001};
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_fault !== 1'b0 || out_in_size !== 7'd0) begin
      n_bad++; $display("FAIL R1 reset state got=%b%b%h exp=00", out_valid, out_fault, out_in_size);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: enables differ; bit 55 decides which applies
    r0_size = 6'd12; r1_size = 6'd12; r0_tag_ign = 1'b0; r1_tag_ign = 1'b1;
    r0_gran = 5'd12; r1_gran = 5'd12;
    in_addr = 64'h12FF_FFFF_FFFF_0000; run_vec("R2");
    in_addr = 64'hFF0F_0000_0000_0000; run_vec("R2");
    r0_tag_ign = 1'b1; r1_tag_ign = 1'b0;
    in_addr = 64'h120F_0000_0000_0000; run_vec("R2");
    in_addr = 64'h12FF_FFFF_FFFF_0000; run_vec("R2");

    for (int gi = 0; gi < 3; gi++)
      for (int i0 = 0; i0 < 9; i0++)
        for (int i1 = 0; i1 < 9; i1++)
          for (int tb = 0; tb < 4; tb++)
            for (int of = 0; of < 4; of++)
              for (int ai = 0; ai < 11; ai++) begin
                r0_gran = 5'(g0l[gi]); r1_gran = 5'(g1l[gi]);
                r0_size = 6'(tl[i0]); r1_size = 6'(tl[i1]);
                r0_tag_ign = tb[0]; r1_tag_ign = tb[1];
                r0_off = of[0]; r1_off = of[1];
                in_addr = al[ai];
                run_vec("");
              end

    // R1: a held-off request gives no result
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 idle out_valid got=%b exp=0", out_valid);
    end
    in_valid = 1'b1; @(negedge clk); in_valid = 1'b0;
    n_chk++;
    if (out_valid !== 1'b1) begin
      n_bad++; $display("FAIL R1 valid got=%b exp=1", out_valid);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule